// File: doc/BRIEF.md
# Queue Error Interrupt Controller

This block holds the miscellaneous interrupt state of one instruction queue. Five hardware event pulses (mailbox write, doorbell overflow, instruction read error, result write error, engine software error) each latch a status bit. Software reads that status through a small register port. It clears status bits through a write-one-to-clear view and forces them through a write-one-to-set view. A matching pair of views sets and clears the per-bit interrupt enables.

A single interrupt output is raised whenever an enabled status bit is pending. The block also owns the queue's run flag. Software turns the flag on or off through a control register. Three of the error sources switch the flag off automatically, whether hardware or software raised them. A continue-on-error input disables that automatic shutdown for diagnostic runs.

Top module: `qerr_irq_ctl`

## Requirements
- R1: After reset the status bits, the enable bits, `queue_en_o` and `irq_o` are all 0.
- R2: A pulse on `evt_i[k]` sets status bit k. The status layout is: bit 0 mailbox, bit 1 doorbell overflow, bit 2 instruction read error, bit 3 result write error, bit 4 engine software error. Reads of address 0 or 1 return the status in bits 4:0, and every higher bit of `reg_rdata_o` reads as 0 for all addresses.
- R3: A write to address 0 clears each status bit whose `reg_wdata_i` bit is 1 and leaves the other status bits unchanged.
- R4: A write to address 1 sets each status bit whose `reg_wdata_i` bit is 1.
- R5: A write to address 2 sets each enable bit (same layout as status) whose data bit is 1, and writing 0 there changes nothing. Reads of address 2 or 3 return the enables in bits 4:0.
- R6: A write to address 3 clears each enable bit whose data bit is 1.
- R7: `irq_o` equals the OR over all bits of (status AND enable), registered one clock later.
- R8: With `cont_on_err_i` = 0, setting status bit 1, 2 or 3, by event or by a write to address 1, clears `queue_en_o` at the same clock edge. This clear wins over a write to address 4 in the same cycle.
- R9: With `cont_on_err_i` = 1, error events leave `queue_en_o` unchanged.
- R10: Setting status bit 0 (mailbox) or bit 4 (engine software error) never clears `queue_en_o`.
- R11: When an event sets a status bit in the same cycle as a write to address 0 clears it, the bit ends up set.
- R12: A write to address 4 loads `queue_en_o` from data bit 0. A read of address 4 returns `queue_en_o` in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 5 | Hardware event pulses, one per status bit |
| cont_on_err_i | input | 1 | 1 keeps the queue running after errors |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational on address) |
| queue_en_o | output | 1 | Queue run flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench goes after the same-cycle collisions. In one, an event pulse meets a clear write to the same bit. A design that lets the clear win would lose the event. In another, an error meets a control write that turns the queue on. A design with the wrong priority would leave a failing queue running. The bench also checks that only the three error bits shut the queue and that this happens for software-injected errors too. A design that keyed the shutdown on the wrong bits, or only on hardware pulses, would be caught. It times the interrupt to the exact cycle, so an unregistered or doubly registered output fails, and it checks that a zero write to the enable-set view leaves the enables untouched.

// File: rtl/qerr_pkg.sv
package qerr_pkg;
   localparam int NUM_SRC    = 5;
   localparam int BIT_MBOX   = 0;
   localparam int BIT_DBOVF  = 1;
   localparam int BIT_RDERR  = 2;
   localparam int BIT_WRERR  = 3;
   localparam int BIT_ENGERR = 4;
   localparam logic [NUM_SRC-1:0] ERR_MASK =
      (NUM_SRC'(1) << BIT_DBOVF) | (NUM_SRC'(1) << BIT_RDERR) | (NUM_SRC'(1) << BIT_WRERR);
   localparam int ADR_ST_CLR = 0;
   localparam int ADR_ST_SET = 1;
   localparam int ADR_EN_SET = 2;
   localparam int ADR_EN_CLR = 3;
   localparam int ADR_CTL    = 4;
endpackage

// File: rtl/qerr_bit_reg.sv
module qerr_bit_reg #(
   parameter int W      = 5,
   parameter bit HW_SET = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hw_set,
   input  logic [W-1:0] sw_set,
   input  logic [W-1:0] sw_clr,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] HW_MASK = HW_SET ? {W{1'b1}} : {W{1'b0}};

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic set_any;
      assign set_any = (hw_set[i] & HW_MASK[i]) | sw_set[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q[i] <= 1'b0;
         else if (set_any) q[i] <= 1'b1;
         else if (sw_clr[i]) q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/qerr_reg_decode.sv
module qerr_reg_decode
   import qerr_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 64
) (
   input  logic               wr,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] status,
   input  logic [NUM_SRC-1:0] enables,
   input  logic               queue_en,
   output logic [NUM_SRC-1:0] st_set,
   output logic [NUM_SRC-1:0] st_clr,
   output logic [NUM_SRC-1:0] en_set,
   output logic [NUM_SRC-1:0] en_clr,
   output logic               ctl_wr,
   output logic               ctl_val,
   output logic [DATA_W-1:0]  rdata
);
   logic [NUM_SRC-1:0] wbits;
   assign wbits = wdata[NUM_SRC-1:0];

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int sel);
      return a == ADDR_W'(sel);
   endfunction

   always_comb begin
      st_clr  = (wr && hit(addr, ADR_ST_CLR)) ? wbits : '0;
      st_set  = (wr && hit(addr, ADR_ST_SET)) ? wbits : '0;
      en_set  = (wr && hit(addr, ADR_EN_SET)) ? wbits : '0;
      en_clr  = (wr && hit(addr, ADR_EN_CLR)) ? wbits : '0;
      ctl_wr  = wr && hit(addr, ADR_CTL);
      ctl_val = wdata[0];
   end

   always_comb begin
      rdata = '0;
      if (hit(addr, ADR_ST_CLR) || hit(addr, ADR_ST_SET))
         rdata[NUM_SRC-1:0] = status;
      else if (hit(addr, ADR_EN_SET) || hit(addr, ADR_EN_CLR))
         rdata[NUM_SRC-1:0] = enables;
      else if (hit(addr, ADR_CTL))
         rdata[0] = queue_en;
   end
endmodule

// File: rtl/qerr_queue_gate.sv
module qerr_queue_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic err_hit,
   input  logic cont_on_err,
   input  logic ctl_wr,
   input  logic ctl_val,
   output logic queue_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    queue_en <= 1'b0;
      else if (err_hit && !cont_on_err) queue_en <= 1'b0;
      else if (ctl_wr)               queue_en <= ctl_val;
   end
endmodule

// File: rtl/qerr_irq_ctl.sv
module qerr_irq_ctl
   import qerr_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [4:0]         evt_i,
   input  logic               cont_on_err_i,
   input  logic               reg_wr_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               queue_en_o,
   output logic               irq_o
);
   if (DATA_W < NUM_SRC) begin : g_bad_data_w
      $error("DATA_W must hold all status bits");
   end
   if ((1 << ADDR_W) <= ADR_CTL) begin : g_bad_addr_w
      $error("ADDR_W too small for the register map");
   end

   logic [NUM_SRC-1:0] status_q, ena_q;
   logic [NUM_SRC-1:0] st_set, st_clr, en_set, en_clr;
   logic               ctl_wr, ctl_val, err_hit;

   qerr_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec (
      .wr(reg_wr_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
      .status(status_q), .enables(ena_q), .queue_en(queue_en_o),
      .st_set(st_set), .st_clr(st_clr), .en_set(en_set), .en_clr(en_clr),
      .ctl_wr(ctl_wr), .ctl_val(ctl_val), .rdata(reg_rdata_o)
   );

   qerr_bit_reg #(.W(NUM_SRC), .HW_SET(1'b1)) i_status (
      .clk(clk), .rst_n(rst_n), .hw_set(evt_i),
      .sw_set(st_set), .sw_clr(st_clr), .q(status_q)
   );

   qerr_bit_reg #(.W(NUM_SRC), .HW_SET(1'b0)) i_enable (
      .clk(clk), .rst_n(rst_n), .hw_set('0),
      .sw_set(en_set), .sw_clr(en_clr), .q(ena_q)
   );

   assign err_hit = |((evt_i | st_set) & ERR_MASK);

   qerr_queue_gate i_gate (
      .clk(clk), .rst_n(rst_n), .err_hit(err_hit),
      .cont_on_err(cont_on_err_i), .ctl_wr(ctl_wr), .ctl_val(ctl_val),
      .queue_en(queue_en_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |(status_q & ena_q);
   end
endmodule

// File: rtl/qerr_irq_ctl_chk.sv
module qerr_irq_ctl_chk
   import qerr_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic [4:0]         evt_i,
   input logic               cont_on_err_i,
   input logic               reg_wr_i,
   input logic [ADDR_W-1:0]  reg_addr_i,
   input logic [DATA_W-1:0]  reg_wdata_i,
   input logic [DATA_W-1:0]  reg_rdata_o,
   input logic               queue_en_o,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] status_q,
   input logic [NUM_SRC-1:0] ena_q
);
   logic sw_err;
   assign sw_err = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_ST_SET))
                   && |(reg_wdata_i[NUM_SRC-1:0] & ERR_MASK);

   // R2
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata_o[DATA_W-1:NUM_SRC] == '0);

   // R7
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_o == $past(|(status_q & ena_q)));

   // R8
   err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cont_on_err_i && ((|(evt_i & ERR_MASK)) || sw_err)) |=> !queue_en_o);

   // R9
   keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cont_on_err_i && queue_en_o && !(reg_wr_i && reg_addr_i == ADDR_W'(ADR_CTL)))
      |=> queue_en_o);

   // R11
   event_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
endmodule

bind qerr_irq_ctl qerr_irq_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cont_on_err_i(cont_on_err_i),
   .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
   .reg_rdata_o(reg_rdata_o), .queue_en_o(queue_en_o), .irq_o(irq_o),
   .status_q(status_q), .ena_q(ena_q)
);

// File: tb/test_qerr_irq_ctl.sv
module test_qerr_irq_ctl;
   localparam int ADDR_W = 3;
   localparam int DATA_W = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [4:0]        evt_i = '0;
   logic              cont_on_err_i = 1'b0;
   logic              reg_wr_i = 1'b0;
   logic [ADDR_W-1:0] reg_addr_i = '0;
   logic [DATA_W-1:0] reg_wdata_i = '0;
   logic [DATA_W-1:0] reg_rdata_o;
   logic              queue_en_o, irq_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   qerr_irq_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_qerr_irq_ctl (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cont_on_err_i(cont_on_err_i),
      .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .queue_en_o(queue_en_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive at negedge, effect lands at the following posedge
   task automatic wr(input int a, input logic [63:0] d);
      @(negedge clk);
      reg_wr_i = 1'b1; reg_addr_i = ADDR_W'(a); reg_wdata_i = d;
      @(negedge clk);
      reg_wr_i = 1'b0;
   endtask

   task automatic rd(input int a, output logic [63:0] d);
      reg_addr_i = ADDR_W'(a);
      #1 d = reg_rdata_o;
   endtask

   task automatic pulse(input logic [4:0] e);
      @(negedge clk);
      evt_i = e;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic t_reset();
      logic [63:0] d;
      rd(0, d); chk("R1 status", d, 0);
      rd(2, d); chk("R1 enables", d, 0);
      chk("R1 queue_en", queue_en_o, 0);
      chk("R1 irq", irq_o, 0);
   endtask

   task automatic t_events();
      logic [63:0] d;
      logic [63:0] exp = 0;
      cont_on_err_i = 1'b1;
      for (int k = 0; k < 5; k++) begin
         pulse(5'(1 << k));
         exp |= 64'(1) << k;
         rd(1, d); chk("R2 event sets bit", d, exp);
      end
      rd(0, d); chk("R2 upper bits zero", d, 64'h1F);
      wr(0, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(0, d); chk("R3 clear all", d, 0);
   endtask

   task automatic t_sw_status();
      logic [63:0] d;
      wr(1, 64'h1F);
      rd(0, d); chk("R4 software set", d, 64'h1F);
      wr(0, 64'h05);
      rd(0, d); chk("R3 partial clear", d, 64'h1A);
      wr(0, 64'h1A);
      rd(0, d); chk("R3 rest cleared", d, 0);
   endtask

   task automatic t_enables();
      logic [63:0] d;
      wr(2, 64'h11);
      rd(2, d); chk("R5 enable set", d, 64'h11);
      rd(3, d); chk("R5 read via clear view", d, 64'h11);
      wr(2, 64'h0);
      rd(2, d); chk("R5 zero write no effect", d, 64'h11);
      wr(3, 64'h01);
      rd(2, d); chk("R6 enable clear", d, 64'h10);
   endtask

   task automatic t_irq();
      // enables now 0x10
      pulse(5'h01);
      @(negedge clk);
      chk("R7 masked bit no irq", irq_o, 0);
      @(negedge clk); evt_i = 5'h10;
      @(negedge clk); evt_i = '0;
      chk("R7 irq not yet", irq_o, 0);
      @(negedge clk);
      chk("R7 irq one cycle later", irq_o, 1);
      wr(0, 64'h1F);
      chk("R7 irq still high", irq_o, 1);
      @(negedge clk);
      chk("R7 irq drops", irq_o, 0);
   endtask

   task automatic t_disable();
      logic [63:0] d;
      cont_on_err_i = 1'b0;
      for (int k = 1; k < 4; k++) begin
         wr(4, 64'h1);
         chk("R12 control write enables", queue_en_o, 1);
         pulse(5'(1 << k));
         chk("R8 hw error stops queue", queue_en_o, 0);
      end
      wr(4, 64'h1);
      rd(4, d); chk("R12 control readback", d, 64'h1);
      pulse(5'h11);
      chk("R10 mailbox and engine error keep queue", queue_en_o, 1);
      wr(1, 64'h08);
      chk("R8 sw error stops queue", queue_en_o, 0);
      @(negedge clk);
      evt_i = 5'h02; reg_wr_i = 1'b1; reg_addr_i = 3'd4; reg_wdata_i = 64'h1;
      @(negedge clk);
      evt_i = '0; reg_wr_i = 1'b0;
      chk("R8 error wins over control write", queue_en_o, 0);
      wr(0, 64'h1F);
   endtask

   task automatic t_cont();
      cont_on_err_i = 1'b1;
      wr(4, 64'h1);
      pulse(5'h0E);
      chk("R9 continue on error", queue_en_o, 1);
      wr(1, 64'h0E);
      chk("R9 sw error ignored", queue_en_o, 1);
      wr(4, 64'h0);
      chk("R12 control write clears", queue_en_o, 0);
      wr(0, 64'h1F);
   endtask

   task automatic t_race();
      logic [63:0] d;
      @(negedge clk);
      evt_i = 5'h04; reg_wr_i = 1'b1; reg_addr_i = 3'd0; reg_wdata_i = 64'h04;
      @(negedge clk);
      evt_i = '0; reg_wr_i = 1'b0;
      rd(0, d); chk("R11 set beats clear (was clear)", d, 64'h04);
      @(negedge clk);
      evt_i = 5'h04; reg_wr_i = 1'b1; reg_addr_i = 3'd0; reg_wdata_i = 64'h1F;
      @(negedge clk);
      evt_i = '0; reg_wr_i = 1'b0;
      rd(0, d); chk("R11 set beats clear (was set)", d, 64'h04);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_events();
      t_sw_status();
      t_enables();
      t_irq();
      t_disable();
      t_cont();
      t_race();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule